// File: doc/BRIEF.md
# Twin-Predicated Vector Move Sequencer

This block turns one vectorised register move into a sequence of register-file write operations. The source and the destination each have a base register, an is-vector flag and a predicate mask. A vector side walks its own element index and skips every element whose mask bit is clear. A scalar side stays on its base register for the whole sequence. One transfer can be issued per cycle.

A single mechanism covers a family of moves. Scalar to vector with a full mask is a splat. Vector to vector with full masks is a copy. A source-only mask gives a gather. A destination-only mask gives a scatter. A one-hot destination mask with a scalar source inserts one element. A one-hot source mask with a scalar destination extracts one element. The sequence stops as soon as either index runs out of the vector length. Each write operation names the register to read and the register to write. A done strobe closes the sequence.

Top module: `vmove_seq`

## Requirements
- R1: After reset, `wr_valid` and `done` are low and stay low until a start is accepted.
- R2: A `start` is accepted only when the sequencer is idle. A `start` that arrives while a sequence is running has no effect on that sequence's writes.
- R3: When the source is a vector, each transfer reads the lowest source element at or above the current source index whose `src_mask` bit (bit k stands for element k) is 1. The source index then moves one past that element.
- R4: When the destination is a vector, the same skipping rule applies to the destination index and `dst_mask`.
- R5: Each write operation carries `wr_src = (src_base + i) mod NREG` and `wr_dst = (dst_base + j) mod NREG`, where i and j are the chosen source and destination element indices.
- R6: A scalar side uses element index 0 for every transfer of the sequence, whatever its mask holds.
- R7: The sequence ends without a further transfer once the next selected element of either vector side would be at or beyond the effective vector length. Mask bits at or above that length never produce a transfer.
- R8: When both sides are scalar and the effective vector length is at least 1, exactly one transfer is issued.
- R9: With an effective vector length of 0, no transfer is issued and `done` still pulses.
- R10: Transfers appear on consecutive cycles starting two cycles after the start is sampled. `done` is a one-cycle pulse in the cycle right after the last transfer, or two cycles after the start when there is no transfer.
- R11: A requested vector length above VLMAX is treated as VLMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a move when idle |
| src_base | input | $clog2(NREG) | Source base register |
| dst_base | input | $clog2(NREG) | Destination base register |
| src_vec | input | 1 | Source is a vector |
| dst_vec | input | 1 | Destination is a vector |
| src_mask | input | VLMAX | Source predicate, one bit per element |
| dst_mask | input | VLMAX | Destination predicate, one bit per element |
| vl | input | $clog2(VLMAX+1) | Requested vector length |
| wr_valid | output | 1 | A write operation is presented |
| wr_dst | output | $clog2(NREG) | Register to write |
| wr_src | output | $clog2(NREG) | Register to read |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Operands are sampled on the clock edge where `start` is high. The first write operation is due on the outputs two edges later, and the following ones come one per cycle with no gaps. `done` follows the last write by exactly one cycle, or comes two cycles after the start when nothing is written. A behavioural reference in the bench steps on the same edge as the design and is compared on every falling edge. Per-move checks also count the writes against the number expected from the masks, and measure the distance from the start or the last write to `done`.

// File: rtl/vmove_seq.sv
module vmove_seq #(
  parameter int NREG  = 32,
  parameter int VLMAX = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(NREG)-1:0]     src_base,
  input  logic [$clog2(NREG)-1:0]     dst_base,
  input  logic                        src_vec,
  input  logic                        dst_vec,
  input  logic [VLMAX-1:0]            src_mask,
  input  logic [VLMAX-1:0]            dst_mask,
  input  logic [$clog2(VLMAX+1)-1:0]  vl,
  output logic                        wr_valid,
  output logic [$clog2(NREG)-1:0]     wr_dst,
  output logic [$clog2(NREG)-1:0]     wr_src,
  output logic                        done
);
  localparam int RW = $clog2(NREG);
  localparam int IW = $clog2(VLMAX + 1);
  localparam logic [IW-1:0] LIM = IW'(VLMAX);

  logic             busy, sv, dv, once;
  logic [RW-1:0]    rs_q, rd_q;
  logic [VLMAX-1:0] sm_q, dm_q;
  logic [IW-1:0]    vl_q, i_q, j_q;
  logic [IW-1:0]    ni, nj;
  logic             fire;

  always_comb begin
    ni = LIM;
    nj = LIM;
    for (int k = VLMAX - 1; k >= 0; k--) begin
      if (IW'(k) >= i_q && sm_q[k]) ni = IW'(k);
      if (IW'(k) >= j_q && dm_q[k]) nj = IW'(k);
    end
    if (!sv) ni = i_q;
    if (!dv) nj = j_q;
  end

  assign fire = busy && !once && (ni < vl_q) && (nj < vl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sv       <= 1'b0;
      dv       <= 1'b0;
      once     <= 1'b0;
      rs_q     <= '0;
      rd_q     <= '0;
      sm_q     <= '0;
      dm_q     <= '0;
      vl_q     <= '0;
      i_q      <= '0;
      j_q      <= '0;
      wr_valid <= 1'b0;
      wr_src   <= '0;
      wr_dst   <= '0;
      done     <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      done     <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sv   <= src_vec;
          dv   <= dst_vec;
          once <= 1'b0;
          rs_q <= src_base;
          rd_q <= dst_base;
          sm_q <= src_mask;
          dm_q <= dst_mask;
          vl_q <= (vl > LIM) ? LIM : vl;
          i_q  <= '0;
          j_q  <= '0;
        end
      end else if (fire) begin
        wr_valid <= 1'b1;
        wr_src   <= rs_q + RW'(ni);
        wr_dst   <= rd_q + RW'(nj);
        i_q      <= ni + IW'(sv);
        j_q      <= nj + IW'(dv);
        once     <= !sv && !dv;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vmove_seq_checks.sv
module vmove_seq_checks #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sv,
  input logic          dv,
  input logic          wr_valid,
  input logic [RW-1:0] wr_src,
  input logic [RW-1:0] wr_dst,
  input logic          done
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_not_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  a_r2_done_closes_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_scalar_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && busy && !sv) |-> $stable(wr_src));

  a_r6_scalar_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && busy && !dv) |-> $stable(wr_dst));

  a_r3_src_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && busy && sv) |-> (wr_src != $past(wr_src)));

  a_r8_dual_scalar_once: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy && !sv && !dv) |=> !wr_valid);
endmodule

bind vmove_seq vmove_seq_checks #(.RW($clog2(NREG))) u_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sv(sv), .dv(dv),
  .wr_valid(wr_valid), .wr_src(wr_src), .wr_dst(wr_dst), .done(done)
);

// File: tb/vmove_seq_bench.sv
module vmove_seq_bench;
  localparam int NREG = 32;
  localparam int VLMAX = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  src_base = '0, dst_base = '0;
  logic        src_vec = 1'b0, dst_vec = 1'b0;
  logic [15:0] src_mask = '0, dst_mask = '0;
  logic [4:0]  vl = '0;
  logic        wr_valid, done;
  logic [4:0]  wr_dst, wr_src;

  int total = 0, bad = 0, cyc = 0;

  vmove_seq #(.NREG(NREG), .VLMAX(VLMAX)) u_vmove_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
    .src_vec(src_vec), .dst_vec(dst_vec), .src_mask(src_mask), .dst_mask(dst_mask),
    .vl(vl), .wr_valid(wr_valid), .wr_dst(wr_dst), .wr_src(wr_src), .done(done)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  int mbusy = 0, monce = 0, mi = 0, mj = 0, mvl = 0, mrs = 0, mrd = 0, msv = 0, mdv = 0;
  logic [15:0] msm = '0, mdm = '0;
  int e_valid = 0, e_done = 0, e_src = 0, e_dst = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mbusy = 0; monce = 0; e_valid = 0; e_done = 0;
    end else begin
      e_valid = 0; e_done = 0;
      if (mbusy == 0) begin
        if (start) begin
          mbusy = 1; monce = 0; mi = 0; mj = 0;
          mrs = int'(src_base); mrd = int'(dst_base);
          msv = int'(src_vec); mdv = int'(dst_vec);
          msm = src_mask; mdm = dst_mask;
          mvl = (int'(vl) > VLMAX) ? VLMAX : int'(vl);
        end
      end else begin
        int a, b;
        a = mi; b = mj;
        if (msv != 0) while (a < VLMAX && !msm[a]) a++;
        if (mdv != 0) while (b < VLMAX && !mdm[b]) b++;
        if (a < mvl && b < mvl && monce == 0) begin
          e_valid = 1;
          e_src = (mrs + a) % NREG;
          e_dst = (mrd + b) % NREG;
          if (msv != 0) mi = a + 1;
          if (mdv != 0) mj = b + 1;
          if (msv == 0 && mdv == 0) monce = 1;
        end else begin
          mbusy = 0; e_done = 1;
        end
      end
    end
  end

  int wcount = 0, last_w = -1, done_at = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (int'(wr_valid) != e_valid || int'(done) != e_done) begin
        bad++;
        $display("FAIL R10 cyc=%0d valid/done actual=%0d/%0d expected=%0d/%0d",
                 cyc, wr_valid, done, e_valid, e_done);
      end else if (wr_valid && (int'(wr_src) != e_src || int'(wr_dst) != e_dst)) begin
        bad++;
        $display("FAIL R5 cyc=%0d src/dst actual=%0d/%0d expected=%0d/%0d",
                 cyc, wr_src, wr_dst, e_src, e_dst);
      end
      if (wr_valid) begin wcount++; last_w = cyc; end
      if (done) done_at = cyc;
    end
  end

  function automatic int pop_in(logic [15:0] m, int n);
    int c = 0;
    for (int k = 0; k < VLMAX; k++) if (k < n && m[k]) c++;
    return c;
  endfunction

  function automatic int want(int sv, int dv, logic [15:0] sm, logic [15:0] dm, int n);
    int e = (n > VLMAX) ? VLMAX : n;
    int ps = pop_in(sm, e), pd = pop_in(dm, e);
    if (sv != 0 && dv != 0) return (ps < pd) ? ps : pd;
    if (sv != 0) return ps;
    if (dv != 0) return pd;
    return (e > 0) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic move(string req, int sb, int db, int sv, int dv,
                      logic [15:0] sm, logic [15:0] dm, int n, int restart);
    int t0, exp;
    exp = want(sv, dv, sm, dm, n);
    @(negedge clk);
    src_base = 5'(sb); dst_base = 5'(db); src_vec = sv[0]; dst_vec = dv[0];
    src_mask = sm; dst_mask = dm; vl = 5'(n); start = 1'b1;
    wcount = 0; last_w = -1; done_at = -1; t0 = cyc;
    @(negedge clk);
    start = (restart != 0);
    src_mask = '1; dst_mask = '1; src_vec = 1'b1; dst_vec = 1'b1; vl = 5'd16;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    while (done_at < 0) @(negedge clk);
    check({req, " count"}, wcount, exp);
    if (exp == 0) check({req, " R10 done latency"}, done_at - t0, 2);
    else check({req, " R10 done after last"}, done_at - last_w, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (wr_valid || done) begin
      bad++;
      $display("FAIL R1 actual=%0d/%0d expected=0/0", wr_valid, done);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    move("R6 splat",            3, 8, 0, 1, 16'h0000, 16'hFFFF, 4, 0);
    move("R5 copy",             2, 20, 1, 1, 16'hFFFF, 16'hFFFF, 6, 0);
    move("R3 gather",           0, 10, 1, 1, 16'h00A5, 16'hFFFF, 8, 0);
    move("R4 scatter",          5, 12, 1, 1, 16'hFFFF, 16'h001A, 6, 0);
    move("R4 gather-scatter",   1, 16, 1, 1, 16'h0F0F, 16'h00F0, 16, 0);
    move("R6 insert",           7, 4, 0, 1, 16'h0000, 16'h0020, 8, 0);
    move("R6 extract",          4, 9, 1, 0, 16'h0008, 16'hFFFF, 8, 0);
    move("R8 both scalar",      6, 11, 0, 0, 16'h0000, 16'h0000, 5, 0);
    move("R9 zero length",      6, 11, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0);
    move("R11 clamp",           30, 25, 1, 1, 16'hFFFF, 16'hFFFF, 20, 0);
    move("R7 mask above vl",    0, 0, 1, 1, 16'hFF00, 16'hFFFF, 8, 0);
    move("R2 start while busy", 0, 3, 1, 1, 16'h0003, 16'hFFFF, 5, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    bad++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule